// File: doc/BRIEF.md
# Clock Lock Reset Sequencer

This block sequences reset at power-up for a chip that derives its working clocks from several on-chip clock synthesizers. It runs only on the free-running reference clock that feeds those synthesizers. No logic in it is clocked by a synthesized clock, so it keeps working while the synthesizers are held in reset or have lost lock. After the external reset is released, the block holds the synthesizers in reset for a programmed settling time on the reference clock. It then lets them start and watches their lock indications.

Each lock indication is brought into the reference domain and debounced. It counts as valid only after it has stayed high for a programmed number of reference cycles. The downstream system reset is released only while every debounced lock is valid at the same time. If any lock drops afterwards, the system reset is asserted again and the debounce starts over.

An alternative timeout mode releases the system reset a fixed worst-case time after the synthesizers are released and does not look at the locks. A chained option suits synthesizers in series, where each lock drives the reset of the next one. In that option only the first synthesizer reset is driven.

Top module: `clk_lock_rst_seq`

## Requirements
- R1: While `ext_rst_n` is low, `sys_rst` is 1 and every bit of `synth_rst` is 1, or only bit 0 when CHAINED=1. This takes effect at once, without a clock edge.
- R2: `ext_rst_n` is released through a two-flop synchronizer. Counting rising edges from the first edge after the release, `synth_rst` falls after edge 2+REF_STABLE_CYC. It stays 0 until `ext_rst_n` is asserted again.
- R3: A lock input that rises after the synthesizers are released counts as valid at edge 2+LOCK_FILT_CYC after the rise, counting from the first edge after the rise. If that lock is the last one missing, `sys_rst` falls after that same edge.
- R4: In lock mode, `sys_rst` stays 1 while any single lock input is low, however long the other locks have been high.
- R5: If a lock input goes low while `sys_rst` is 0, `sys_rst` is 1 after the third edge following the drop. When the lock returns, counting from the first edge after its return, `sys_rst` falls again only after edge 2+LOCK_FILT_CYC.
- R6: Lock inputs have no effect while `synth_rst` is asserted. With all locks held high through reset, `sys_rst` falls after edge 2+REF_STABLE_CYC+LOCK_FILT_CYC following the reset release.
- R7: With USE_TIMEOUT=1, `sys_rst` falls after edge 2+REF_STABLE_CYC+TIMEOUT_CYC following the reset release, whatever the lock inputs do. It is not asserted again until `ext_rst_n` goes low.
- R8: With CHAINED=1, only `synth_rst[0]` is ever asserted. The other bits stay 0.
- R9: `sys_rst` is 1 in every cycle in which `synth_rst[0]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; clocks all logic |
| ext_rst_n | input | 1 | Asynchronous external reset, active low |
| lock_in | input | N_SYNTH | Lock indication from each synthesizer, asynchronous |
| synth_rst | output | N_SYNTH | Reset to each synthesizer, active high |
| sys_rst | output | 1 | Downstream system reset, active high |

## Verification
The hardest situation to reach from the ports is a lock glitch that falls inside an interval that has already started counting. To be exposed, it has to land exactly where a missed counter clear would release the system reset early. The stimulus drives directed reset and lock edges on falling clock edges, so each transition falls on a known rising edge. It then injects bursts of glitches with random length and random position on random lock bits. Each expected reassertion and release cycle is computed from the glitch's own timing. Timeout mode is exercised on a second instance while its locks toggle at random.

// File: rtl/clk_lock_rst_seq.sv
module clk_lock_rst_seq #(
  parameter int N_SYNTH        = 3,
  parameter int REF_STABLE_CYC = 20,
  parameter int LOCK_FILT_CYC  = 8,
  parameter int TIMEOUT_CYC    = 40,
  parameter bit USE_TIMEOUT    = 1'b0,
  parameter bit CHAINED        = 1'b0
) (
  input  logic               ref_clk,
  input  logic               ext_rst_n,
  input  logic [N_SYNTH-1:0] lock_in,
  output logic [N_SYNTH-1:0] synth_rst,
  output logic               sys_rst
);

  localparam int RW = $clog2(REF_STABLE_CYC + 1);
  localparam int FW = $clog2(LOCK_FILT_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [RW-1:0] REF_LAST  = RW'(REF_STABLE_CYC - 1);
  localparam logic [FW-1:0] FILT_LAST = FW'(LOCK_FILT_CYC - 1);
  localparam logic [TW-1:0] TO_LAST   = TW'(TIMEOUT_CYC - 1);

  logic [1:0]         rst_sync;
  logic               rst_i;
  logic [RW-1:0]      ref_cnt;
  logic               ref_done;
  logic [N_SYNTH-1:0] lock_m, lock_s, filt_ok;
  logic               all_ok;

  always_ff @(posedge ref_clk or negedge ext_rst_n)
    if (!ext_rst_n) rst_sync <= 2'b00;
    else            rst_sync <= {rst_sync[0], 1'b1};

  assign rst_i = ~rst_sync[1];

  always_ff @(posedge ref_clk or posedge rst_i)
    if (rst_i) begin
      ref_cnt  <= '0;
      ref_done <= 1'b0;
    end else if (!ref_done) begin
      if (ref_cnt == REF_LAST) ref_done <= 1'b1;
      else                     ref_cnt  <= ref_cnt + 1'b1;
    end

  always_ff @(posedge ref_clk or posedge rst_i)
    if (rst_i) begin
      lock_m <= '0;
      lock_s <= '0;
    end else begin
      lock_m <= lock_in;
      lock_s <= lock_m;
    end

  for (genvar i = 0; i < N_SYNTH; i++) begin : g_filt
    logic [FW-1:0] cnt;
    always_ff @(posedge ref_clk or posedge rst_i)
      if (rst_i) begin
        cnt        <= '0;
        filt_ok[i] <= 1'b0;
      end else if (!ref_done || !lock_s[i]) begin
        cnt        <= '0;
        filt_ok[i] <= 1'b0;
      end else if (!filt_ok[i]) begin
        if (cnt == FILT_LAST) filt_ok[i] <= 1'b1;
        else                  cnt        <= cnt + 1'b1;
      end
  end

  assign all_ok = &filt_ok;

  for (genvar i = 0; i < N_SYNTH; i++) begin : g_srst
    if (i == 0 || !CHAINED) begin : g_drv
      assign synth_rst[i] = ~ref_done;
    end else begin : g_chain
      assign synth_rst[i] = 1'b0;
    end
  end

  if (USE_TIMEOUT) begin : g_tmo
    logic [TW-1:0] to_cnt;
    logic          to_done;
    always_ff @(posedge ref_clk or posedge rst_i)
      if (rst_i) begin
        to_cnt  <= '0;
        to_done <= 1'b0;
      end else if (ref_done && !to_done) begin
        if (to_cnt == TO_LAST) to_done <= 1'b1;
        else                   to_cnt  <= to_cnt + 1'b1;
      end
    assign sys_rst = ~to_done;
  end else begin : g_lck
    assign sys_rst = ~(ref_done & all_ok);
  end

  AST_SYS_COVERS_SYNTH: assert property (@(posedge ref_clk) disable iff (rst_i)
    synth_rst[0] |-> sys_rst); // R9
  AST_SYNTH_ONE_WAY: assert property (@(posedge ref_clk) disable iff (rst_i)
    !synth_rst[0] |=> !synth_rst[0]); // R2
  AST_RELEASE_NEEDS_LOCK: assert property (@(posedge ref_clk) disable iff (rst_i)
    $fell(sys_rst) |-> (USE_TIMEOUT || $past(&lock_s))); // R3
  AST_DROP_REASSERTS: assert property (@(posedge ref_clk) disable iff (rst_i)
    (!USE_TIMEOUT && !(&lock_s)) |=> sys_rst); // R5
  AST_TIMEOUT_HOLDS: assert property (@(posedge ref_clk) disable iff (rst_i)
    (USE_TIMEOUT && !sys_rst) |=> !sys_rst); // R7

endmodule

// File: tb/test_clk_lock_rst_seq.sv
`timescale 1ns/1ps
module test_clk_lock_rst_seq;
  localparam int N = 3, R = 20, F = 8, T = 40;

  logic clk = 1'b0;
  logic ext_rst_n = 1'b0, ext_rst_n_b = 1'b0;
  logic [N-1:0] lock = '0, lock_b = '0;
  logic [N-1:0] srst, srst_b;
  logic sys_rst, sys_rst_b;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clk_lock_rst_seq #(.N_SYNTH(N), .REF_STABLE_CYC(R), .LOCK_FILT_CYC(F),
    .TIMEOUT_CYC(T), .USE_TIMEOUT(1'b0), .CHAINED(1'b0)) i_clk_lock_rst_seq (
    .ref_clk(clk), .ext_rst_n(ext_rst_n), .lock_in(lock),
    .synth_rst(srst), .sys_rst(sys_rst));

  clk_lock_rst_seq #(.N_SYNTH(N), .REF_STABLE_CYC(R), .LOCK_FILT_CYC(F),
    .TIMEOUT_CYC(T), .USE_TIMEOUT(1'b1), .CHAINED(1'b1)) i_clk_lock_rst_seq_to (
    .ref_clk(clk), .ext_rst_n(ext_rst_n_b), .lock_in(lock_b),
    .synth_rst(srst_b), .sys_rst(sys_rst_b));

  function automatic logic [N-1:0] exp_srst(bit chained, bit in_rst);
    if (!in_rst) return '0;
    return chained ? N'(1) : '1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    #5;
    check("R1 reset sys", 32'(sys_rst), 1);
    check("R1 reset synth", 32'(srst), 32'(exp_srst(0, 1)));
    check("R8 chained reset synth", 32'(srst_b), 32'(exp_srst(1, 1)));
    @(negedge clk);
    ext_rst_n = 1'b1;
    edges(1 + R);
    check("R2 synth held", 32'(srst), 32'(exp_srst(0, 1)));
    edges(1);
    check("R2 synth released", 32'(srst), 0);
    check("R9 sys held", 32'(sys_rst), 1);

    lock = 3'b011;
    edges(F + 6);
    check("R4 one lock missing", 32'(sys_rst), 1);
    lock = 3'b111;
    edges(1 + F);
    check("R3 before filter", 32'(sys_rst), 1);
    edges(1);
    check("R3 after filter", 32'(sys_rst), 0);

    for (int it = 0; it < 12; it++) begin
      int k = int'($urandom % N);
      int g = 1 + int'($urandom % 4);
      lock[k] = 1'b0;
      for (int e = 1; e <= g + 2 + F; e++) begin
        edges(1);
        if (e == g) lock[k] = 1'b1;
        if (e == 3) check("R5 reassert", 32'(sys_rst), 1);
        if (e == g + 1 + F) check("R5 refilter held", 32'(sys_rst), 1);
        if (e == g + 2 + F) check("R5 refilter release", 32'(sys_rst), 0);
      end
      edges(int'($urandom % 3));
    end

    lock = 3'b101;
    edges(2);
    lock = 3'b111;
    edges(F - 2);
    lock = 3'b110;
    edges(1);
    lock = 3'b111;
    edges(F + 1);
    check("R5 glitch mid-filter held", 32'(sys_rst), 1);
    edges(1);
    check("R5 glitch mid-filter release", 32'(sys_rst), 0);

    #3 ext_rst_n = 1'b0;
    #1;
    check("R1 async sys", 32'(sys_rst), 1);
    check("R1 async synth", 32'(srst), 32'(exp_srst(0, 1)));
    @(negedge clk);
    ext_rst_n = 1'b1;
    edges(2 + R);
    check("R6 synth released", 32'(srst), 0);
    check("R6 locks ignored", 32'(sys_rst), 1);
    edges(F - 1);
    check("R6 held", 32'(sys_rst), 1);
    edges(1);
    check("R6 release", 32'(sys_rst), 0);

    ext_rst_n_b = 1'b1;
    for (int e = 1; e <= 2 + R + T + 30; e++) begin
      edges(1);
      lock_b = N'($urandom);
      if (e == 1 + R) check("R8 chained held", 32'(srst_b), 32'(exp_srst(1, 1)));
      if (e == 2 + R) check("R8 chained released", 32'(srst_b), 0);
      if (e == 1 + R + T) check("R7 timeout held", 32'(sys_rst_b), 1);
      if (e >= 2 + R + T) check("R7 timeout released", 32'(sys_rst_b), 0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule